// File: doc/BRIEF.md
# Compressed Cache Set Controller

This block manages the bookkeeping of one set in a compressed cache. The set has four address tags. They share a data area that holds only two uncompressed 64-byte lines, which is sixteen 8-byte segments. A compressed line takes between one and eight segments and an uncompressed line always takes eight. Because there are more tags than there is data space, a tag may stay valid after its data has left the set. Such a tag records that the line would still be on chip if more of the set were compressed.

The block handles two kinds of request: lookup and allocate. Each request carries an address tag, a compressed flag, a size in segments and permission bits. Lookup results are combinational from the current state and the request. They give a data hit, a tag-only match, the matching tag's depth in a four-entry recency stack, and the line's compression status. The block also reports the number of free segments. State changes on the clock edge while a request is valid.

On allocate, the block evicts data from the least recently used lines that still hold data until the new line fits. Evicted lines keep their tags. Data storage, compaction of segments and the meaning of the permission bits belong to the surrounding cache.

Top module: `cs_set_ctrl`

## Requirements
- R1: After reset every tag is invalid, `free_segs` is 16 and no request reports a hit or a tag-only match.
- R2: A lookup whose tag matches a valid entry with data present raises `rsp_hit`, and `rsp_comp` gives that entry's stored compressed flag.
- R3: A tag that matches a valid entry with no data present raises `rsp_tag_only` and not `rsp_hit`. A tag with no matching valid entry raises neither.
- R4: `rsp_depth` gives the matching entry's recency position, where 0 is most recent and 3 is least recent. A hit or an allocate moves the entry to position 0, and entries that were above it move down by one. A lookup that does not hit leaves the order unchanged.
- R5: After an allocate, the line is valid and present at position 0 with the requested compressed flag. An uncompressed line takes 8 segments whatever `req_size` says, and a compressed line takes `req_size`, which is 1 to 8.
- R6: To make room, data is evicted from present lines other than the target, starting with the deepest position and moving upward, and only while the free count is below the new line's size. An evicted entry keeps its valid tag with data marked absent.
- R7: An allocate whose tag matches no valid entry uses the entry at position 3 and discards that entry's old tag and data.
- R8: An allocate whose tag already matches an entry reuses that entry, so a tag is never held twice. The entry's old segments count as free before any eviction is decided.
- R9: `free_segs` equals 16 minus the sum of the sizes of present lines. It is never negative.
- R10: While `req_valid` is low, no tag, data-presence flag, size or recency position changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request applies its state change at the next edge |
| req_alloc | input | 1 | 1 = allocate, 0 = lookup |
| req_tag | input | TAG_W | Address tag of the request |
| req_comp | input | 1 | 1 = line is compressed |
| req_size | input | SIZE_W | Compressed size in segments (1 to 8) |
| req_perm | input | PERM_W | Permission bits stored with the tag |
| rsp_hit | output | 1 | Tag matched with data present |
| rsp_tag_only | output | 1 | Tag matched with data absent |
| rsp_depth | output | DEPTH_W | Recency position of the matching tag |
| rsp_comp | output | 1 | Compressed flag of the hit line |
| free_segs | output | FREE_W | Unoccupied segments in the data area |

## Verification
The assertions assume that a compressed allocate carries a size from 1 to 8. Sizes outside that range would break the space bookkeeping, so the stimulus draws compressed sizes only from that range. Uncompressed allocates carry random sizes, because the block must ignore them. Tags are drawn from a pool of six values, so matches, tag-only matches and replacements of the bottom entry all occur often. Roughly one request in ten is sent with `req_valid` low, and this checks that such requests leave the state unchanged.

// File: rtl/cs_pkg.sv
package cs_pkg;
    parameter int NUM_TAGS      = 4;
    parameter int SEGS_PER_LINE = 8;
    parameter int DATA_LINES    = 2;
    parameter int TAG_W         = 20;
    parameter int PERM_W        = 2;

    localparam int TOTAL_SEGS = SEGS_PER_LINE * DATA_LINES;
    localparam int SIZE_W     = $clog2(SEGS_PER_LINE + 1);
    localparam int FREE_W     = $clog2(TOTAL_SEGS + 1);
    localparam int DEPTH_W    = $clog2(NUM_TAGS);
    localparam int ACC_W      = FREE_W + 1;

    typedef struct packed {
        logic              valid;
        logic              present;
        logic              comp;
        logic [SIZE_W-1:0] size;
        logic [PERM_W-1:0] perm;
        logic [TAG_W-1:0]  tag;
    } entry_t;

    typedef entry_t [NUM_TAGS-1:0]              entry_arr_t;
    typedef logic   [NUM_TAGS-1:0][DEPTH_W-1:0] depth_arr_t;

    function automatic logic [SIZE_W-1:0] seg_need(input logic comp, input logic [SIZE_W-1:0] size);
        return comp ? size : SIZE_W'(SEGS_PER_LINE);
    endfunction
endpackage

// File: rtl/cs_tag_match.sv
module cs_tag_match
    import cs_pkg::*;
(
    input  entry_arr_t           ents,
    input  logic [TAG_W-1:0]     tag,
    output logic [NUM_TAGS-1:0]  match_vec,
    output logic                 any_match,
    output logic [DEPTH_W-1:0]   match_idx
);
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            match_vec[i] = ents[i].valid && (ents[i].tag == tag);
            if (match_vec[i]) match_idx = DEPTH_W'(i);
        end
        any_match = |match_vec;
    end
endmodule

// File: rtl/cs_lru_stack.sv
module cs_lru_stack
    import cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               touch_en,
    input  logic [DEPTH_W-1:0] touch_idx,
    output depth_arr_t         depth,
    output logic [DEPTH_W-1:0] bottom_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TAGS; i++) depth[i] <= DEPTH_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < NUM_TAGS; i++) begin
                if (DEPTH_W'(i) == touch_idx)          depth[i] <= '0;
                else if (depth[i] < depth[touch_idx])  depth[i] <= depth[i] + 1'b1;
            end
        end
    end

    always_comb begin
        bottom_idx = '0;
        for (int i = 0; i < NUM_TAGS; i++)
            if (depth[i] == DEPTH_W'(NUM_TAGS - 1)) bottom_idx = DEPTH_W'(i);
    end

    logic [NUM_TAGS-1:0] occupied;
    always_comb begin
        occupied = '0;
        for (int i = 0; i < NUM_TAGS; i++) occupied[depth[i]] = 1'b1;
    end

    assert_stack_perm_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(occupied) == NUM_TAGS);
endmodule

// File: rtl/cs_evict_plan.sv
module cs_evict_plan
    import cs_pkg::*;
(
    input  entry_arr_t           ents,
    input  depth_arr_t           depth,
    input  logic [DEPTH_W-1:0]   target_idx,
    input  logic [SIZE_W-1:0]    need,
    output logic [NUM_TAGS-1:0]  evict_vec,
    output logic [ACC_W-1:0]     room
);
    logic [ACC_W-1:0] used;

    always_comb begin
        used = '0;
        for (int i = 0; i < NUM_TAGS; i++)
            if (ents[i].present && DEPTH_W'(i) != target_idx)
                used = used + ACC_W'(ents[i].size);
        room      = ACC_W'(TOTAL_SEGS) - used;
        evict_vec = '0;
        for (int d = NUM_TAGS - 1; d >= 0; d--) begin
            for (int i = 0; i < NUM_TAGS; i++) begin
                if (depth[i] == DEPTH_W'(d) && DEPTH_W'(i) != target_idx &&
                    ents[i].present && room < ACC_W'(need)) begin
                    evict_vec[i] = 1'b1;
                    room         = room + ACC_W'(ents[i].size);
                end
            end
        end
    end
endmodule

// File: rtl/cs_set_ctrl.sv
module cs_set_ctrl
    import cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_alloc,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic               req_comp,
    input  logic [SIZE_W-1:0]  req_size,
    input  logic [PERM_W-1:0]  req_perm,
    output logic               rsp_hit,
    output logic               rsp_tag_only,
    output logic [DEPTH_W-1:0] rsp_depth,
    output logic               rsp_comp,
    output logic [FREE_W-1:0]  free_segs
);
    entry_arr_t          ent_q;
    depth_arr_t          depth;
    logic [NUM_TAGS-1:0] match_vec, evict_vec;
    logic                any_match;
    logic [DEPTH_W-1:0]  match_idx, bottom_idx, target_idx, touch_idx;
    logic [SIZE_W-1:0]   need;
    logic [ACC_W-1:0]    room, occ_sum;
    logic                touch_en;

    cs_tag_match u_match (
        .ents(ent_q), .tag(req_tag), .match_vec(match_vec),
        .any_match(any_match), .match_idx(match_idx)
    );

    assign rsp_hit      = any_match && ent_q[match_idx].present;
    assign rsp_tag_only = any_match && !ent_q[match_idx].present;
    assign rsp_depth    = any_match ? depth[match_idx] : '0;
    assign rsp_comp     = rsp_hit && ent_q[match_idx].comp;

    assign target_idx = any_match ? match_idx : bottom_idx;
    assign need       = seg_need(req_comp, req_size);
    assign touch_en   = req_valid && (req_alloc || rsp_hit);
    assign touch_idx  = req_alloc ? target_idx : match_idx;

    cs_lru_stack u_lru (
        .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
        .depth(depth), .bottom_idx(bottom_idx)
    );

    cs_evict_plan u_plan (
        .ents(ent_q), .depth(depth), .target_idx(target_idx), .need(need),
        .evict_vec(evict_vec), .room(room)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (req_valid && req_alloc) begin
            for (int i = 0; i < NUM_TAGS; i++)
                if (evict_vec[i]) ent_q[i].present <= 1'b0;
            ent_q[target_idx] <= '{valid: 1'b1, present: 1'b1, comp: req_comp,
                                   size: need, perm: req_perm, tag: req_tag};
        end
    end

    always_comb begin
        occ_sum = '0;
        for (int i = 0; i < NUM_TAGS; i++)
            if (ent_q[i].present) occ_sum = occ_sum + ACC_W'(ent_q[i].size);
    end
    assign free_segs = FREE_W'(ACC_W'(TOTAL_SEGS) - occ_sum);

    assert_free_range_R9: assert property (@(posedge clk) disable iff (rst)
        occ_sum <= ACC_W'(TOTAL_SEGS));
    assert_tag_unique_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));
    assert_room_found_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_alloc) |-> room >= ACC_W'(need));
    assert_alloc_resident_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_alloc) |=> ent_q[$past(target_idx)].present && ent_q[$past(target_idx)].valid);
    assert_hit_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_tag_only));
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(ent_q) && $stable(depth));
endmodule

// File: tb/test_cs_set_ctrl.sv
module test_cs_set_ctrl;
    import cs_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_alloc = 1'b0, req_comp = 1'b0;
    logic [TAG_W-1:0]   req_tag = '0;
    logic [SIZE_W-1:0]  req_size = '0;
    logic [PERM_W-1:0]  req_perm = '0;
    logic               rsp_hit, rsp_tag_only, rsp_comp;
    logic [DEPTH_W-1:0] rsp_depth;
    logic [FREE_W-1:0]  free_segs;

    always #10 clk = ~clk;

    cs_set_ctrl i_cs_set_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_alloc(req_alloc),
        .req_tag(req_tag), .req_comp(req_comp), .req_size(req_size), .req_perm(req_perm),
        .rsp_hit(rsp_hit), .rsp_tag_only(rsp_tag_only), .rsp_depth(rsp_depth),
        .rsp_comp(rsp_comp), .free_segs(free_segs)
    );

    int n_vec = 0, n_bad = 0;
    bit mv[4], mp[4], mc[4];
    int ms[4], md[4];
    logic [TAG_W-1:0] mt[4];

    task automatic chk(string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int m_find(logic [TAG_W-1:0] t);
        for (int i = 0; i < 4; i++) if (mv[i] && mt[i] == t) return i;
        return -1;
    endfunction

    function automatic int m_free();
        int s = 16;
        for (int i = 0; i < 4; i++) if (mp[i]) s -= ms[i];
        return s;
    endfunction

    task automatic m_touch(int k);
        for (int j = 0; j < 4; j++) if (md[j] < md[k]) md[j]++;
        md[k] = 0;
    endtask

    task automatic m_alloc(logic [TAG_W-1:0] t, bit c, int sz);
        int need = c ? sz : 8;
        int k = m_find(t);
        int fr;
        if (k < 0) for (int i = 0; i < 4; i++) if (md[i] == 3) k = i;
        mp[k] = 1'b0;
        fr = m_free();
        for (int d = 3; d >= 0; d--)
            for (int i = 0; i < 4; i++)
                if (md[i] == d && i != k && mp[i] && fr < need) begin
                    mp[i] = 1'b0;
                    fr += ms[i];
                end
        mv[k] = 1'b1; mp[k] = 1'b1; mc[k] = c; ms[k] = need; mt[k] = t;
        m_touch(k);
    endtask

    task automatic apply(bit v, bit a, logic [TAG_W-1:0] t, bit c, int sz);
        int k;
        bit eh;
        @(negedge clk);
        req_valid = v; req_alloc = a; req_tag = t; req_comp = c;
        req_size = SIZE_W'(sz); req_perm = PERM_W'(sz);
        #2;
        k  = m_find(t);
        eh = (k >= 0) && mp[k];
        chk("R2 hit", int'(rsp_hit), int'(eh));
        chk("R3 tag_only", int'(rsp_tag_only), int'(k >= 0 && !mp[k]));
        if (k >= 0) chk("R4 depth", int'(rsp_depth), md[k]);
        if (eh) chk("R2 comp", int'(rsp_comp), int'(mc[k]));
        chk("R9 free", int'(free_segs), m_free());
        @(posedge clk);
        if (v) begin
            if (a) m_alloc(t, c, sz);
            else if (eh) m_touch(k);
        end
    endtask

    task automatic peek(logic [TAG_W-1:0] t, string what, int hit, int tonly, int dep, int fr);
        @(negedge clk);
        req_valid = 1'b0; req_alloc = 1'b0; req_tag = t;
        #2;
        chk({what, " hit"}, int'(rsp_hit), hit);
        chk({what, " tag_only"}, int'(rsp_tag_only), tonly);
        if (hit != 0 || tonly != 0) chk({what, " depth"}, int'(rsp_depth), dep);
        chk({what, " free"}, int'(free_segs), fr);
    endtask

    localparam logic [TAG_W-1:0] TA = 20'h00A01, TB = 20'h00B02, TC = 20'h00C03,
                                 TD = 20'h00D04, TE = 20'h00E05, TF = 20'h00F06;

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            mv[i] = 0; mp[i] = 0; mc[i] = 0; ms[i] = 0; md[i] = i; mt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: empty set after reset
        peek(TA, "R1 reset", 0, 0, 0, 16);
        // R5: uncompressed line takes 8 segments, req_size ignored
        apply(1, 1, TA, 0, 2);
        peek(TA, "R5 uncompressed", 1, 0, 0, 8);
        apply(1, 1, TB, 1, 6);
        peek(TB, "R5 compressed", 1, 0, 0, 2);
        // R6: A is the deepest line holding data and loses it, keeping its tag
        apply(1, 1, TC, 1, 4);
        peek(TA, "R6 evicted tag", 0, 1, 2, 6);
        peek(TB, "R6 survivor", 1, 0, 1, 6);
        apply(1, 1, TD, 1, 3);
        peek(TA, "R4 depth shift", 0, 1, 3, 3);
        // R7: no match, the bottom tag (A) is dropped
        apply(1, 1, TE, 1, 2);
        peek(TA, "R7 dropped", 0, 0, 0, 1);
        // R10: an allocate with req_valid low changes nothing
        apply(0, 1, TF, 1, 8);
        peek(TF, "R10 idle", 0, 0, 0, 1);
        // R8: re-allocating B reuses its entry and frees its 6 segments first
        apply(1, 1, TB, 1, 1);
        peek(TB, "R8 reuse", 1, 0, 0, 6);
        peek(TE, "R8 neighbour", 1, 0, 1, 6);
        // R4: a lookup hit on C moves it to the top
        apply(1, 0, TC, 0, 0);
        peek(TC, "R4 hit top", 1, 0, 0, 6);

        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 3000; n++) begin
            int  sel = $urandom_range(0, 5);
            bit  a   = $urandom_range(0, 1);
            bit  c   = $urandom_range(0, 3) != 0;
            int  sz  = c ? $urandom_range(1, 8) : $urandom_range(0, 15);
            bit  v   = $urandom_range(0, 9) != 0;
            apply(v, a, 20'h00100 + 20'(sel), c, sz);
        end
        peek(20'h00100, "R9 final", int'(m_find(20'h00100) >= 0 && mp[m_find(20'h00100)]),
             int'(m_find(20'h00100) >= 0 && !mp[m_find(20'h00100)]),
             (m_find(20'h00100) >= 0) ? md[m_find(20'h00100)] : 0, m_free());
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule